// File: doc/BRIEF.md
# JTAG indirect register access bridge

This block is a 20-bit scan data register that lets a test host reach a bank of internal registers. The host never addresses those registers through the scan chain directly. A separately supplied address selects the target. Each scan then carries a command that starts a read or a write of that target, or that only observes progress. The bridge runs on the test clock. An external tap controller supplies one-cycle capture, shift and update strobes, and the bridge answers on TDO.

A scan may be shorter than 20 bits. The captured word holds a busy flag in bit 0, so one shift is enough to poll. Read results are right-justified, so a narrow result needs only a few shifts. Write data is left-justified, so a narrow target is written with few shifts. While an operation is in progress, any further read or write command is dropped without notice. A command shifted in during the scan whose capture saw busy low is accepted on that scan's update, so a host can poll and issue the next command in one pass.

The back end uses a four-phase request/acknowledge handshake:

- The bridge raises exactly one of its read or write strobes. It holds the strobe, the address and the write data steady until the acknowledge, seen through a synchronizer, arrives. Only then does it drop the strobe.
- The target raises the acknowledge when the operation is done. It keeps the read data steady while the acknowledge is high. It lowers the acknowledge once the strobe is low.
- No new request is raised until the acknowledge has gone low again.
- There is no other back-pressure. A host that issues commands while busy simply has them ignored.

Top module: `jind_bridge`

## Requirements
- R1: After reset, TDO is 0 and both back-end strobes are low. A 20-bit scan taken before any operation returns all zeros.
- R2: On capture (sel and cap_dr high at a clock edge), the scan register loads these fields: bit 0 is busy, bits 18:1 are the last read result, and bit 19 is 0.
- R3: Each shift edge moves the register one place toward bit 0, with TDI entering bit 19 and TDO showing bit 0. Bits therefore leave LSB first, and an 8-bit read result is complete after 9 shifts (busy first, then data bits 0..7).
- R4: On update, the opcode in bits 19:18 is decoded as follows: 10 starts a read, 11 starts a write, and 00 or 01 (poll) starts nothing on either strobe.
- R5: A write delivers register bits 17:0 as write data. A write shifted at reduced length n places its data MSB-aligned at bit 17. For example, an 8-bit value shifted in 10 bits appears on be_wdata[17:10].
- R6: A read can be started by shifting only 2 bits (a 0, then a 1) and updating. It reads the target chosen by dr_addr.
- R7: Busy goes high on the edge where a read or write starts, and reads back as 1 until the synchronized acknowledge has completed its four-phase cycle. The read result is latched when the acknowledge arrives.
- R8: A read or write command whose scan captured busy = 1 is ignored. No strobe rises and the address and write data do not change.
- R9: A command shifted in the same scan whose capture saw busy = 0 starts on that scan's update, even after earlier scans were ignored.
- R10: The back end follows the four-phase rules above. The two strobes are never high together. Address and write data are stable while a strobe is high. A strobe falls only after the acknowledge was high. A strobe never rises while the acknowledge is high.
- R11: The read result shown in captures is kept until the next read completes. A completed write does not change it.
- R12: The address is sampled when an operation starts. Changing dr_addr while busy does not change be_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | This data register is selected by the instruction |
| cap_dr | input | 1 | Capture strobe from the tap controller |
| shift_dr | input | 1 | Shift strobe from the tap controller |
| upd_dr | input | 1 | Update strobe from the tap controller |
| tdi | input | 1 | Serial data in |
| dr_addr | input | ADDR_W | Target register address, supplied separately |
| tdo | output | 1 | Serial data out (bit 0 of the scan register) |
| be_addr | output | ADDR_W | Back-end address, latched at start |
| be_rd | output | 1 | Back-end read request, held until acknowledge |
| be_wr | output | 1 | Back-end write request, held until acknowledge |
| be_wdata | output | DATA_W | Back-end write data, left-justified |
| be_rdata | input | DATA_W | Back-end read data, valid while be_ack is high |
| be_ack | input | 1 | Back-end completion acknowledge (four-phase) |

## Verification
The bench builds the bridge with DATA_W = 18, ADDR_W = 3 and SYNC_STAGES = 3. The three-flop synchronizer stretches the busy window. That longer window lets a full 20-bit command scan land entirely inside an operation, which exercises the ignore rule. It also makes the overlap test run through several ignored scans before one scan sees busy fall.

The target model in the bench answers after a 12-cycle latency. Its upper four addresses act as 8-bit registers, which brings the left-justified 10-shift write and the right-justified 9-shift read into play. Its lower four addresses act as 18-bit registers and take full-width transfers.

// File: rtl/jind_pkg.sv
package jind_pkg;
  typedef enum logic [1:0] {
    OP_POLL_A = 2'b00,
    OP_POLL_B = 2'b01,
    OP_READ   = 2'b10,
    OP_WRITE  = 2'b11
  } op_e;
endpackage

// File: rtl/jind_sync.sv
module jind_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) ff[0] <= 1'b0;
          else        ff[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) ff[g] <= 1'b0;
          else        ff[g] <= ff[g-1];
        end
      end
    end
  endgenerate

  assign q = ff[STAGES-1];
endmodule

// File: rtl/jind_scan.sv
module jind_scan #(
  parameter int DATA_W = 18,
  localparam int SR_W = DATA_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              cap,
  input  logic              shf,
  input  logic              upd,
  input  logic              tdi,
  input  logic              busy_now,
  input  logic [DATA_W-1:0] rd_result,
  output logic              tdo,
  output logic              upd_go,
  output logic [1:0]        cmd_op,
  output logic [DATA_W-1:0] cmd_data,
  output logic              cap_busy
);
  logic [SR_W-1:0] sr;

  // Capture loads {0, result, busy}; shifting moves toward bit 0.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr       <= '0;
      cap_busy <= 1'b0;
    end else if (sel) begin
      if (cap) begin
        sr       <= {1'b0, rd_result, busy_now};
        cap_busy <= busy_now;
      end else if (shf) begin
        sr <= {tdi, sr[SR_W-1:1]};
      end
    end
  end

  assign tdo      = sr[0];
  assign cmd_op   = sr[SR_W-1:SR_W-2];
  assign cmd_data = sr[DATA_W-1:0];
  // An update counts only when the capture of this scan saw an idle bridge.
  assign upd_go   = sel && upd && !cap_busy;
endmodule

// File: rtl/jind_ctrl.sv
module jind_ctrl
  import jind_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [1:0]        op,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              ack_s,
  input  logic [DATA_W-1:0] be_rdata,
  output logic              busy,
  output logic              be_rd,
  output logic              be_wr,
  output logic [ADDR_W-1:0] be_addr,
  output logic [DATA_W-1:0] be_wdata,
  output logic [DATA_W-1:0] rd_result
);
  logic req_q;
  logic is_wr_q;
  op_e  op_d;
  logic start;

  assign op_d  = op_e'(op);
  assign start = go && !busy && (op_d == OP_READ || op_d == OP_WRITE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q     <= 1'b0;
      is_wr_q   <= 1'b0;
      be_addr   <= '0;
      be_wdata  <= '0;
      rd_result <= '0;
    end else if (start) begin
      req_q   <= 1'b1;
      is_wr_q <= (op_d == OP_WRITE);
      be_addr <= addr_in;
      if (op_d == OP_WRITE) be_wdata <= wdata_in;
    end else if (req_q && ack_s) begin
      req_q <= 1'b0;
      if (!is_wr_q) rd_result <= be_rdata;
    end
  end

  // Busy covers the request phase and the acknowledge return phase.
  assign busy  = req_q || ack_s;
  assign be_rd = req_q && !is_wr_q;
  assign be_wr = req_q && is_wr_q;
endmodule

// File: rtl/jind_bridge.sv
module jind_bridge #(
  parameter int DATA_W      = 18,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              tck,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              cap_dr,
  input  logic              shift_dr,
  input  logic              upd_dr,
  input  logic              tdi,
  input  logic [ADDR_W-1:0] dr_addr,
  output logic              tdo,
  output logic [ADDR_W-1:0] be_addr,
  output logic              be_rd,
  output logic              be_wr,
  output logic [DATA_W-1:0] be_wdata,
  input  logic [DATA_W-1:0] be_rdata,
  input  logic              be_ack
);
  logic              ack_s;
  logic              busy;
  logic              upd_go;
  logic              scan_cap_busy;
  logic [1:0]        cmd_op;
  logic [DATA_W-1:0] cmd_data;
  logic [DATA_W-1:0] rd_result;

  jind_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(tck), .rst_n(rst_n), .d(be_ack), .q(ack_s)
  );

  jind_scan #(.DATA_W(DATA_W)) u_scan (
    .clk(tck), .rst_n(rst_n), .sel(sel), .cap(cap_dr), .shf(shift_dr),
    .upd(upd_dr), .tdi(tdi), .busy_now(busy), .rd_result(rd_result),
    .tdo(tdo), .upd_go(upd_go), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .cap_busy(scan_cap_busy)
  );

  jind_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(tck), .rst_n(rst_n), .go(upd_go), .op(cmd_op), .wdata_in(cmd_data),
    .addr_in(dr_addr), .ack_s(ack_s), .be_rdata(be_rdata), .busy(busy),
    .be_rd(be_rd), .be_wr(be_wr), .be_addr(be_addr), .be_wdata(be_wdata),
    .rd_result(rd_result)
  );
endmodule

// File: rtl/jind_bridge_chk.sv
module jind_bridge_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 18
) (
  input logic              tck,
  input logic              rst_n,
  input logic              sel,
  input logic              upd_dr,
  input logic              be_rd,
  input logic              be_wr,
  input logic [ADDR_W-1:0] be_addr,
  input logic [DATA_W-1:0] be_wdata,
  input logic              be_ack,
  input logic              cap_busy
);
  a_r10_one_strobe: assert property (@(posedge tck) disable iff (!rst_n)
    !(be_rd && be_wr));

  a_r10_fields_stable: assert property (@(posedge tck) disable iff (!rst_n)
    ((be_rd || be_wr) && $past(be_rd || be_wr)) |-> ($stable(be_addr) && $stable(be_wdata)));

  a_r10_drop_after_ack: assert property (@(posedge tck) disable iff (!rst_n)
    $fell(be_rd || be_wr) |-> $past(be_ack));

  a_r10_no_rise_in_ack: assert property (@(posedge tck) disable iff (!rst_n)
    $rose(be_rd || be_wr) |-> !be_ack);

  a_r8_ignored_when_busy: assert property (@(posedge tck) disable iff (!rst_n)
    (sel && upd_dr && cap_busy) |=> (!$rose(be_rd || be_wr) && $stable(be_addr)));
endmodule

bind jind_bridge jind_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .tck(tck), .rst_n(rst_n), .sel(sel), .upd_dr(upd_dr), .be_rd(be_rd),
  .be_wr(be_wr), .be_addr(be_addr), .be_wdata(be_wdata), .be_ack(be_ack),
  .cap_busy(scan_cap_busy)
);

// File: tb/jind_bridge_bench.sv
module jind_bridge_bench;
  localparam int DW = 18;
  localparam int AW = 3;
  localparam int LAT = 12;

  logic tck = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, cap_dr = 1'b0, shift_dr = 1'b0, upd_dr = 1'b0, tdi = 1'b0;
  logic [AW-1:0] dr_addr = '0;
  logic tdo, be_rd, be_wr, be_ack;
  logic [AW-1:0] be_addr;
  logic [DW-1:0] be_wdata, be_rdata;

  int total = 0, bad = 0;
  int wr_count = 0, rd_count = 0, hs_err = 0;
  bit done = 1'b0;

  always #2 tck = ~tck;

  jind_bridge #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(3)) u_jind_bridge (
    .tck(tck), .rst_n(rst_n), .sel(sel), .cap_dr(cap_dr), .shift_dr(shift_dr),
    .upd_dr(upd_dr), .tdi(tdi), .dr_addr(dr_addr), .tdo(tdo), .be_addr(be_addr),
    .be_rd(be_rd), .be_wr(be_wr), .be_wdata(be_wdata), .be_rdata(be_rdata),
    .be_ack(be_ack)
  );

  // Target bank: addresses 0..3 hold 18 bits, 4..7 hold 8 bits.
  logic [DW-1:0] bank [0:7];
  int cnt = 0;
  logic prev_req = 1'b0;
  logic [AW-1:0] prev_addr = '0;
  logic [DW-1:0] prev_wdata = '0;

  always @(posedge tck) begin
    if (!rst_n) begin
      be_ack   <= 1'b0;
      be_rdata <= '0;
      cnt      <= 0;
      for (int i = 0; i < 8; i++) bank[i] <= '0;
    end else if ((be_rd || be_wr) && !be_ack) begin
      if (cnt == LAT) begin
        be_ack <= 1'b1;
        cnt    <= 0;
        if (be_wr) begin
          wr_count <= wr_count + 1;
          if (be_addr >= 3'd4) bank[be_addr] <= {10'd0, be_wdata[17:10]};
          else                 bank[be_addr] <= be_wdata;
        end else begin
          rd_count <= rd_count + 1;
          be_rdata <= bank[be_addr];
        end
      end else begin
        cnt <= cnt + 1;
      end
    end else if (!(be_rd || be_wr)) begin
      be_ack <= 1'b0;
    end
  end

  // Handshake watcher for R10.
  always @(posedge tck) begin
    if (rst_n) begin
      if (be_rd && be_wr) hs_err <= hs_err + 1;
      if ((be_rd || be_wr) && prev_req && (be_addr != prev_addr || be_wdata != prev_wdata))
        hs_err <= hs_err + 1;
      if (!(be_rd || be_wr) && prev_req && !be_ack) hs_err <= hs_err + 1;
    end
    prev_req   <= be_rd || be_wr;
    prev_addr  <= be_addr;
    prev_wdata <= be_wdata;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic scan(input logic [19:0] cmd, input int n, input bit upd,
                      output logic [19:0] dout);
    dout = '0;
    @(negedge tck);
    sel = 1'b1; cap_dr = 1'b1;
    @(negedge tck);
    cap_dr = 1'b0;
    for (int i = 0; i < n; i++) begin
      shift_dr = 1'b1;
      tdi = cmd[20-n+i];
      dout[i] = tdo;
      @(negedge tck);
    end
    shift_dr = 1'b0;
    if (upd) begin
      upd_dr = 1'b1;
      @(negedge tck);
      upd_dr = 1'b0;
    end
  endtask

  task automatic poll_wait();
    logic [19:0] d;
    for (int k = 0; k < 300; k++) begin
      scan(20'h0, 1, 1'b0, d);
      if (d[0] == 1'b0) return;
    end
    check("R7 busy never fell", 1, 0);
  endtask

  task automatic t_reset();
    logic [19:0] d;
    check("R1 tdo after reset", tdo, 0);
    check("R1 strobes after reset", {be_rd, be_wr}, 0);
    scan(20'h0, 20, 1'b0, d);
    check("R1 R2 first capture", d, 0);
  endtask

  task automatic t_write_full();
    logic [19:0] d;
    int w0 = wr_count;
    dr_addr = 3'd2;
    scan({2'b11, 18'h2A5C3}, 20, 1'b1, d);
    check("R4 R7 write strobe", {be_wr, be_rd}, 2'b10);
    check("R5 full write data", be_wdata, 18'h2A5C3);
    check("R6 write address", be_addr, 2);
    scan(20'h0, 1, 1'b0, d);
    check("R7 busy high during op", d[0], 1);
    poll_wait();
    check("R7 strobe dropped", be_wr, 0);
    check("R5 target got write", bank[2], 18'h2A5C3);
    check("R5 one write", wr_count - w0, 1);
  endtask

  task automatic t_read_short();
    logic [19:0] d;
    dr_addr = 3'd2;
    scan({2'b10, 18'h0}, 2, 1'b1, d);
    check("R6 short read strobe", {be_rd, be_wr}, 2'b10);
    poll_wait();
    scan(20'h0, 20, 1'b0, d);
    check("R2 R3 read result", d[18:1], 18'h2A5C3);
    check("R2 bit19 and busy", {d[19], d[0]}, 0);
  endtask

  task automatic t_byte();
    logic [19:0] d;
    dr_addr = 3'd5;
    scan({2'b11, 8'hB7, 10'h0}, 10, 1'b1, d);
    check("R5 left-justified byte", be_wdata[17:10], 8'hB7);
    poll_wait();
    scan({2'b10, 18'h0}, 2, 1'b1, d);
    poll_wait();
    scan(20'h0, 9, 1'b0, d);
    check("R3 9-shift byte read", d[8:0], {8'hB7, 1'b0});
  endtask

  task automatic t_ignore();
    logic [19:0] d;
    int w0 = wr_count;
    dr_addr = 3'd1;
    scan({2'b11, 18'h11111}, 20, 1'b1, d);
    scan({2'b11, 18'h22222}, 20, 1'b1, d);
    check("R8 captured busy", d[0], 1);
    check("R8 wdata unchanged", be_wdata, 18'h11111);
    poll_wait();
    check("R8 single write", wr_count - w0, 1);
    check("R8 target value", bank[1], 18'h11111);
  endtask

  task automatic t_poll_update();
    logic [19:0] d;
    int w0 = wr_count, r0 = rd_count;
    scan({2'b01, 18'h3FFFF}, 20, 1'b1, d);
    check("R4 poll opcode starts nothing", {be_rd, be_wr}, 0);
    scan({2'b00, 18'h3FFFF}, 20, 1'b1, d);
    check("R4 poll 00 starts nothing", {be_rd, be_wr}, 0);
    repeat (30) @(negedge tck);
    check("R4 no back-end traffic", (wr_count - w0) + (rd_count - r0), 0);
  endtask

  task automatic t_overlap();
    logic [19:0] d;
    int ignored = 0;
    bit started = 1'b0;
    dr_addr = 3'd3;
    scan({2'b11, 18'h0ABCD}, 20, 1'b1, d);
    for (int k = 0; k < 50 && !started; k++) begin
      scan({2'b11, 18'h35AA5}, 20, 1'b1, d);
      if (d[0] == 1'b0) started = 1'b1;
      else ignored++;
    end
    check("R9 overlap start", {started, be_wr}, 2'b11);
    check("R9 overlap data", be_wdata, 18'h35AA5);
    check("R9 some scans ignored", ignored > 0, 1);
    poll_wait();
    check("R9 target value", bank[3], 18'h35AA5);
  endtask

  task automatic t_hold();
    logic [19:0] d;
    dr_addr = 3'd2;
    scan({2'b10, 18'h0}, 2, 1'b1, d);
    poll_wait();
    dr_addr = 3'd0;
    scan({2'b11, 18'h3C3C3}, 20, 1'b1, d);
    poll_wait();
    scan(20'h0, 19, 1'b0, d);
    check("R11 result held over write", d[18:1], 18'h2A5C3);
  endtask

  task automatic t_addr_latch();
    logic [19:0] d;
    dr_addr = 3'd6;
    scan({2'b11, 8'h5E, 10'h0}, 10, 1'b1, d);
    dr_addr = 3'd0;
    @(negedge tck);
    check("R12 address held", be_addr, 6);
    poll_wait();
    check("R12 target 6 written", bank[6], 18'h5E);
    check("R12 target 0 untouched", bank[0], 18'h3C3C3);
  endtask

  initial begin
    repeat (4) @(negedge tck);
    rst_n = 1'b1;
    @(negedge tck);
    t_reset();
    t_write_full();
    t_read_short();
    t_byte();
    t_ignore();
    t_poll_update();
    t_overlap();
    t_hold();
    t_addr_latch();
    check("R10 handshake rules", hs_err, 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge tck);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule